// File: doc/BRIEF.md
# I2C Register-File Target Interface

This block is the serial front end of a 32-entry byte register array. It observes the open-drain clock and data lines of a two-wire I2C bus, recognises bus conditions, answers a single fixed 7-bit device identifier (1101000) and moves bytes between the bus and the array through a plain synchronous read/write port. A controller writes by sending the identifier with the direction bit clear, then a register address, then any number of data bytes. It reads either from wherever the internal register pointer currently stands, or from a chosen address by first sending a write-addressed transfer that carries only the register address and then a repeated START with the direction bit set.

The pointer lives across transfers. It is zero after reset and advances by one for each byte written or sent, wrapping from 1Fh to 00h. A current-address read therefore resumes exactly where the previous access stopped. The block never stretches the clock. It changes its SDA pull-down only while SCL is low.

The controller state machine has the states ST_IDLE, ST_DEV, ST_DEV_ACK, ST_REG, ST_REG_ACK, ST_WDATA, ST_WDATA_ACK, ST_RLOAD, ST_RWAIT, ST_RDATA and ST_RACK. A START in any state goes to ST_DEV, and a STOP in any state goes to ST_IDLE. The other transitions are:

- ST_DEV: goes to ST_DEV_ACK when a full byte carries a matching identifier, and to ST_IDLE when it does not.
- ST_DEV_ACK: on the SCL fall, goes to ST_RLOAD when the direction bit is 1, and to ST_REG when it is 0.
- ST_REG to ST_REG_ACK on a full byte, then to ST_WDATA on the SCL fall.
- ST_WDATA to ST_WDATA_ACK on a full byte, then back to ST_WDATA on the SCL fall.
- ST_RLOAD to ST_RWAIT to ST_RDATA, one clock each.
- ST_RDATA to ST_RACK on the eighth SCL fall.
- ST_RACK: on the SCL fall, goes to ST_RLOAD after a controller ACK, and to ST_IDLE after a NACK.

Top module: `i2c_regfile_target`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both seen after two-flop synchronisation. A START at any point abandons the byte in progress and begins address reception. A STOP returns the block to idle. A partly received data byte is never written.
- R2: The first byte after a START is accepted only when its upper seven bits are 1101000. The block then pulls SDA low through the ninth clock. On a mismatch SDA stays released, and nothing on the bus is acknowledged or written until the next START.
- R3: In a write transfer, the byte after the address byte loads the pointer from its low five bits. Each further byte is written to the array at the pointer with a one-cycle reg_we pulse, the pointer then advances by one, and every byte is acknowledged.
- R4: After reset the pointer is 00h. A read that follows the address byte directly starts at the current pointer.
- R5: A random read is a write-addressed transfer carrying the register address, then a repeated START and the identifier with bit 0 = 1. It returns data starting from that address.
- R6: For each byte sent, the block pulses reg_re for one cycle with reg_addr at the pointer. It takes reg_rdata on the next clock and then advances the pointer by one.
- R7: The pointer wraps from 1Fh to 00h on both reads and writes.
- R8: The block sends another byte after each controller ACK in the ninth clock of a read byte. After a NACK it releases SDA and sends nothing until the next START.
- R9: Bytes move most significant bit first in both directions.
- R10: The SDA pull-down changes only while the synchronised SCL is low, except on the cycle after a START or STOP.
- R11: reg_we and reg_re are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Sampled level of the bus clock line |
| sda_in | input | 1 | Sampled level of the bus data line |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| reg_addr | output | 5 | Array address (the register pointer) |
| reg_we | output | 1 | One-cycle array write strobe |
| reg_wdata | output | 8 | Data written to the array |
| reg_re | output | 1 | One-cycle array read strobe |
| reg_rdata | input | 8 | Array data, valid one clock after reg_re |

## Verification
The assertions check on every cycle these properties:
- a START always leads to address reception;
- a mismatched identifier leaves SDA released;
- every write strobe advances the pointer by one, and the pointer wraps at 1Fh;
- the pull-down only moves while SCL is low;
- the write and read strobes never overlap.

The bench's scenarios are needed to show the transfer-level behaviour. That covers the power-up pointer, current-address continuation across transfers, random reads through a repeated START, wrap-around in both directions, release after a controller NACK, and the rejection of truncated bytes aborted by START or STOP. The bench checks these by comparing received bytes, acknowledge bits and every array write against a behavioural memory and pointer model.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RLOAD,
        ST_RWAIT,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_chain;
    logic [TOP:0] sda_chain;
    logic         scl_prev;
    logic         sda_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[TOP-1:0], scl_in};
            sda_chain <= {sda_chain[TOP-1:0], sda_in};
            scl_prev  <= scl_chain[TOP];
            sda_prev  <= sda_chain[TOP];
        end
    end

    assign scl_s     = scl_chain[TOP];
    assign sda_s     = sda_chain[TOP];
    assign scl_rise  = scl_s && !scl_prev;
    assign scl_fall  = !scl_s && scl_prev;
    assign bus_start = scl_s && scl_prev && sda_prev && !sda_s;
    assign bus_stop  = scl_s && scl_prev && !sda_prev && sda_s;

endmodule

// File: rtl/i2c_reg_pointer.sv
module i2c_reg_pointer #(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] PTR_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R7: the pointer wraps from its top value to zero
    assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr == PTR_MAX) |=> (ptr == '0));

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ID = 7'h68,
    parameter int         PTR_W  = 5,
    parameter int         DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              ptr_load,
    output logic [PTR_W-1:0]  ptr_load_val,
    output logic              ptr_step,
    output logic              reg_we,
    output logic              reg_re,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              sda_pull
);
    localparam int                CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(DATA_W - 1);

    tgt_state_e        state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              master_ack;
    logic              byte_done;
    logic              id_hit;

    assign byte_done = (bit_cnt == CNT_FULL) && scl_fall;
    assign id_hit    = (shreg[DATA_W-1:DATA_W-7] == DEV_ID);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (bus_start) begin
            state_nx = ST_DEV;
        end else if (bus_stop) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_DEV:       if (byte_done) state_nx = id_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall)  state_nx = shreg[0] ? ST_RLOAD : ST_REG;
                ST_REG:       if (byte_done) state_nx = ST_REG_ACK;
                ST_REG_ACK:   if (scl_fall)  state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_nx = ST_WDATA;
                ST_RLOAD:     state_nx = ST_RWAIT;
                ST_RWAIT:     state_nx = ST_RDATA;
                ST_RDATA:     if (scl_fall && bit_cnt == CNT_LAST) state_nx = ST_RACK;
                ST_RACK:      if (scl_fall)  state_nx = master_ack ? ST_RLOAD : ST_IDLE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath: shift register, bit counter, controller acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            master_ack <= 1'b0;
        end else if (bus_start || bus_stop) begin
            bit_cnt <= '0;
        end else begin
            case (state)
                ST_DEV, ST_REG, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[DATA_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_DEV_ACK, ST_REG_ACK, ST_WDATA_ACK: bit_cnt <= '0;
                ST_RWAIT: begin
                    shreg   <= reg_rdata;
                    bit_cnt <= '0;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        shreg   <= {shreg[DATA_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_RACK: if (scl_rise) master_ack <= !sda_s;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull = 1'b0;
        reg_we   = 1'b0;
        reg_re   = 1'b0;
        ptr_load = 1'b0;
        ptr_step = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_REG_ACK, ST_WDATA_ACK: sda_pull = 1'b1;
            ST_REG:   ptr_load = byte_done;
            ST_WDATA: begin
                reg_we   = byte_done;
                ptr_step = byte_done;
            end
            ST_RLOAD: reg_re   = 1'b1;
            ST_RWAIT: ptr_step = 1'b1;
            ST_RDATA: sda_pull = !shreg[DATA_W-1];
            ST_IDLE, ST_DEV, ST_RACK: ;
            default: ;
        endcase
    end

    assign reg_wdata    = shreg;
    assign ptr_load_val = shreg[PTR_W-1:0];

    // R1: a START always leads to address reception
    assert_start_to_dev_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (state == ST_DEV));

    // R2: a rejected identifier never produces a pull-down
    assert_mismatch_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && byte_done && !id_hit) |=> !sda_pull);

    // R3: each array write advances the pointer by one
    assert_write_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    // R10: the pull-down moves only while SCL is low
    assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && !$past(bus_start) && !$past(bus_stop)) |-> !scl_s);

    // R11: write and read strobes never overlap
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, reg_re}));

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
    parameter logic [6:0] DEV_ID      = 7'h68,
    parameter int         PTR_W       = 5,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [PTR_W-1:0]  reg_addr,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic             scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic             ptr_load, ptr_step;
    logic [PTR_W-1:0] ptr_load_val;
    logic [PTR_W-1:0] ptr;

    i2c_bus_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_reg_pointer #(
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .step     (ptr_step),
        .ptr      (ptr)
    );

    i2c_tgt_ctrl #(
        .DEV_ID (DEV_ID),
        .PTR_W  (PTR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_s        (scl_s),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .bus_start    (bus_start),
        .bus_stop     (bus_stop),
        .ptr          (ptr),
        .reg_rdata    (reg_rdata),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_step     (ptr_step),
        .reg_we       (reg_we),
        .reg_re       (reg_re),
        .reg_wdata    (reg_wdata),
        .sda_pull     (sda_pull)
    );

    assign reg_addr = ptr;

endmodule

// File: tb/tb_i2c_regfile_target.sv
module tb_i2c_regfile_target;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull;
    logic [4:0] reg_addr;
    logic       reg_we, reg_re;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_regfile_target dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_pull  (sda_pull),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata)
    );

    // register array attached to the port
    logic [7:0] mem [32];
    initial for (int i = 0; i < 32; i++) mem[i] = 8'((i * 7 + 3) % 256);
    always @(posedge clk) begin
        if (reg_we) mem[reg_addr] <= reg_wdata;
        if (reg_re) reg_rdata <= mem[reg_addr];
    end

    // behavioural reference model
    int         ref_mem [32];
    int         ref_ptr;
    logic [12:0] wq [$];
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    bit         done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison of array writes and strobes
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (reg_we) begin
                if (wq.size() == 0) begin
                    chk(1'b0, "R3 unexpected write", int'({reg_addr, reg_wdata}), 0);
                end else begin
                    chk({reg_addr, reg_wdata} == wq[0], "R3 write addr/data",
                        int'({reg_addr, reg_wdata}), int'(wq[0]));
                    void'(wq.pop_front());
                end
            end
            if (reg_we && reg_re) chk(1'b0, "R11 strobes overlap", 1, 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = !sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = !give_ack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1; tick(Q - 2);
    endtask

    task automatic read_n(input int n, input string req);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            read_byte(k != n - 1, b);
            chk(int'(b) == ref_mem[ref_ptr], req, int'(b), ref_mem[ref_ptr]);
            ref_ptr = (ref_ptr + 1) % 32;
        end
    endtask

    task automatic wr_seq(input int addr, input int n, input int seed);
        bit a;
        bus_start();
        send_byte(8'hD0, a); chk(a, "R2 id ack on write", int'(a), 1);
        send_byte(8'(addr), a); chk(a, "R3 reg addr ack", int'(a), 1);
        ref_ptr = addr % 32;
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'((seed + k * 37) % 256);
            wq.push_back({5'(ref_ptr), d});
            ref_mem[ref_ptr] = int'(d);
            send_byte(d, a); chk(a, "R3 data ack", int'(a), 1);
            ref_ptr = (ref_ptr + 1) % 32;
        end
        bus_stop();
    endtask

    task automatic rd_cur(input int n, input string req);
        bit a;
        bus_start();
        send_byte(8'hD1, a); chk(a, "R2 id ack on read", int'(a), 1);
        read_n(n, req);
        bus_stop();
    endtask

    task automatic rd_rand(input int addr, input int n, input string req);
        bit a;
        bus_start();
        send_byte(8'hD0, a); chk(a, "R5 dummy write id ack", int'(a), 1);
        send_byte(8'(addr), a); chk(a, "R5 reg addr ack", int'(a), 1);
        ref_ptr = addr % 32;
        bus_start();
        send_byte(8'hD1, a); chk(a, "R5 read id ack after repeated start", int'(a), 1);
        read_n(n, req);
        bus_stop();
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < 32; i++) ref_mem[i] = (i * 7 + 3) % 256;
        ref_ptr = 0;
        tick(5);
        chk(sda_pull == 1'b0, "R1 reset sda released", int'(sda_pull), 0);
        chk(reg_we == 1'b0 && reg_re == 1'b0, "R11 reset strobes idle", int'({reg_we, reg_re}), 0);
        rst_n = 1'b1;
        tick(4);

        // R4: power-up pointer is zero
        rd_cur(3, "R4 read from power-up pointer");

        // R3, R9: sequential write
        wr_seq(5, 4, 8'h81);

        // R4: current-address read continues at pointer
        rd_cur(2, "R4 current-address continuation");

        // R5, R6, R9: random read of written bytes
        rd_rand(5, 4, "R6 random read data msb-first R9");

        // R7: wrap on write and on read
        wr_seq(30, 4, 8'h5A);
        chk(ref_ptr == 2, "R7 model pointer wrapped", ref_ptr, 2);
        rd_rand(29, 5, "R7 read across 1Fh to 00h");
        rd_cur(1, "R7 read after wrapped pointer");

        // R8: after a NACK the line stays released
        bus_start();
        send_byte(8'hD1, a); chk(a, "R8 id ack", int'(a), 1);
        read_n(1, "R8 single byte read");
        chk(sda_pull == 1'b0, "R8 released after NACK", int'(sda_pull), 0);
        read_byte(1'b0, b);
        chk(b == 8'hFF, "R8 no data after NACK", int'(b), 8'hFF);
        bus_stop();

        // R2: mismatched identifiers are ignored
        bus_start();
        send_byte(8'hA0, a); chk(!a, "R2 mismatch nack", int'(a), 0);
        send_byte(8'h03, a); chk(!a, "R2 following byte ignored", int'(a), 0);
        send_byte(8'h55, a); chk(!a, "R2 data ignored", int'(a), 0);
        bus_stop();
        bus_start();
        send_byte(8'hD3, a); chk(!a, "R2 id 1101001 rejected", int'(a), 0);
        bus_stop();
        rd_cur(1, "R2 pointer untouched by rejected transfer");

        // R1: START aborts partial address byte
        bus_start();
        send_bits(8'hD0, 5);
        wr_seq(10, 2, 8'h3C);

        // R1: STOP aborts partial data byte, no write
        bus_start();
        send_byte(8'hD0, a); chk(a, "R1 id ack", int'(a), 1);
        send_byte(8'd20, a); chk(a, "R1 reg addr ack", int'(a), 1);
        ref_ptr = 20;
        send_bits(8'hE7, 3);
        bus_stop();
        tick(4);
        chk(wq.size() == 0, "R1 no write from truncated byte", wq.size(), 0);
        rd_cur(2, "R1 pointer after aborted byte");

        // R1: START in the middle of a data byte, then a fresh read
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'd3, a);
        ref_ptr = 3;
        send_bits(8'h99, 6);
        rd_cur(1, "R1 restart after partial data byte");

        tick(20);
        chk(wq.size() == 0, "R3 all expected writes seen", wq.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule